// File: doc/BRIEF.md
# Three-Wire Addressed Display Loader

This block is the serial port through which a host microcontroller fills the image and brightness registers of a multiplexed display controller. The host raises a select line, then presents one bit per rising edge of a shift clock on a data line. The first three bits of a frame form an address. The bits after them form the payload. When the select line drops, the block copies the payload into the register the address names, provided the frame had the right length for that register.

Three 56-bit segment image planes and a 10-bit brightness word are held here and driven to the scanning logic. All three host lines are asynchronous to the system clock. Each passes through a two-stage synchroniser, and the shift clock is edge-detected in the system domain. A synchronous active-low reset, tied to power-on, clears every register. The block makes no attempt to check framing beyond bit counting.

Top module: `tw_disp_loader`

## Requirements
- R1: While reset is asserted, and directly after it is released, all three image planes and the brightness word read zero.
- R2: The three address bits are sent most significant bit first. Code 1 selects image plane 1, code 2 selects plane 2 and code 3 selects plane 3.
- R3: In an image frame, the first payload bit lands in bit 55 of the selected plane and the last payload bit lands in bit 0. A 1 stores as 1, meaning the segment is lit.
- R4: Address code 4 followed by exactly 10 payload bits loads the brightness word, first payload bit into bit 9.
- R5: A register changes only after the select line falls. While the select line stays high, all outputs keep their prior values.
- R6: A frame is discarded when its bit count is wrong: an image frame needs exactly 3+56 bits and a brightness frame exactly 3+10 bits. Shorter frames, longer frames and frames of the other register's length are all discarded.
- R7: Address codes 0, 5, 6 and 7 leave every register unchanged, whatever the frame length.
- R8: Shift-clock edges while the select line is low shift nothing. They change no output and do not disturb the next frame.
- R9: A committed frame leaves every register it did not address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| ser_cs | input | 1 | Frame select from host, high during a frame (asynchronous) |
| ser_clk | input | 1 | Host shift clock, data taken on its rising edge (asynchronous) |
| ser_dat | input | 1 | Host serial data, positive logic (asynchronous) |
| seg_plane1 | output | 56 | Segment image plane 1 |
| seg_plane2 | output | 56 | Segment image plane 2 |
| seg_plane3 | output | 56 | Segment image plane 3 |
| dim_level | output | 10 | Brightness word |

## Verification
A corrupted bit counter or address register shows up the moment the select line falls. Within four system clocks the wrong plane is loaded, a valid frame is dropped, or a bad-length frame is accepted, so a sweep over every address code and the lengths around each valid count exposes it one frame later. A payload shifted in the wrong order shows as a bit-reversed or offset plane value, which single-bit patterns at both ends of the field pin down. Spurious shifting while deselected would corrupt the next frame's count, and the frame sent right after idle clocking catches it.

// File: rtl/tw_loader_pkg.sv
// Shared constants and address decode for the three-wire display loader.
// Assumes the address field is fixed at 3 bits and that the planes take
// codes 1..PLANES while the brightness word takes code 4.
package tw_loader_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned PLANES = 3;
    localparam logic [ADDR_W-1:0] ADR_DIM = 3'd4;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_PLANE = 2'd1,
        TGT_DIM   = 2'd2
    } tgt_e;

    // Classifies an address code by the kind of register it names.
    function automatic tgt_e target_of(input logic [ADDR_W-1:0] code);
        if (code != '0 && code <= ADDR_W'(PLANES)) begin
            return TGT_PLANE;
        end else if (code == ADR_DIM) begin
            return TGT_DIM;
        end else begin
            return TGT_NONE;
        end
    endfunction

endpackage

// File: rtl/tw_pin_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous host pins.
// Assumes each bit is independent. Bits sent together with setup margin
// keep their mutual order because every bit sees the same latency.
module tw_pin_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw pins through the stage chain, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/tw_frame_shifter.sv
// Frame receiver: detects shift-clock rises and select falls in the system
// domain, shifts address then payload bits, counts them, and on the select
// fall issues a one-cycle write request if the length suits the address.
// Assumes DIM_W < SEG_W and that the inputs are already synchronised.
module tw_frame_shifter
    import tw_loader_pkg::*;
#(
    parameter int unsigned SEG_W = 56,
    parameter int unsigned DIM_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              dat_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SEG_W-1:0]  wr_data
);

    localparam int unsigned SEG_FRAME = ADDR_W + SEG_W;
    localparam int unsigned DIM_FRAME = ADDR_W + DIM_W;
    localparam int unsigned CNT_MAX   = SEG_FRAME + 1;
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

    logic              cs_q;
    logic              sclk_q;
    logic              sclk_rise;
    logic              cs_fall;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SEG_W-1:0]  data_q;
    logic              len_ok;

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign cs_fall   = cs_q & ~cs_s;

    // Shift address bits first, then payload bits, and count them (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_s) begin
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (sclk_rise) begin
            if (cnt_q < CNT_W'(ADDR_W)) begin
                addr_q <= {addr_q[ADDR_W-2:0], dat_s};
            end else begin
                data_q <= {data_q[SEG_W-2:0], dat_s};
            end
            if (cnt_q != CNT_W'(CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Decide whether the bit count matches the kind of register addressed.
    always_comb begin
        unique case (target_of(addr_q))
            TGT_PLANE: len_ok = (cnt_q == CNT_W'(SEG_FRAME));
            TGT_DIM:   len_ok = (cnt_q == CNT_W'(DIM_FRAME));
            default:   len_ok = 1'b0;
        endcase
    end

    // Register a single-cycle write request when a frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= cs_fall && len_ok;
            if (cs_fall) begin
                wr_addr <= addr_q;
                wr_data <= data_q;
            end
        end
    end

    // R6: the bit counter never passes its saturation value.
    a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CNT_MAX));

    // R5: a write request only follows a select fall.
    a_r5_write_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(cs_fall));

    // R8: with select low the frame state is empty next cycle.
    a_r8_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (cnt_q == '0 && addr_q == '0));

endmodule

// File: rtl/tw_latch_bank.sv
// Register bank: three segment image planes and one brightness word,
// each loaded from a write request whose address selects it.
// Assumes the request is already length-checked and lasts one cycle.
module tw_latch_bank
    import tw_loader_pkg::*;
#(
    parameter int unsigned SEG_W = 56,
    parameter int unsigned DIM_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [SEG_W-1:0]             wr_data,
    output logic [PLANES-1:0][SEG_W-1:0] plane_o,
    output logic [DIM_W-1:0]             dim_o
);

    logic [PLANES-1:0] plane_we;
    logic              dim_we;

    // Per-plane write enables from the address code.
    for (genvar p = 0; p < PLANES; p++) begin : g_we
        assign plane_we[p] = wr_en && (wr_addr == ADDR_W'(p + 1));
    end
    assign dim_we = wr_en && (wr_addr == ADR_DIM);

    // Load the addressed image plane, clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_o <= '0;
        end else begin
            for (int p = 0; p < PLANES; p++) begin
                if (plane_we[p]) begin
                    plane_o[p] <= wr_data;
                end
            end
        end
    end

    // Load the brightness word from the low payload bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dim_o <= '0;
        end else if (dim_we) begin
            dim_o <= wr_data[DIM_W-1:0];
        end
    end

    // R1: the first cycle out of reset sees cleared registers.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (plane_o == '0 && dim_o == '0));

    // R5: without a write request nothing changes.
    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(plane_o) && $stable(dim_o)));

    // R7: a request for an unused code changes nothing.
    a_r7_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && target_of(wr_addr) == TGT_NONE) |=> ($stable(plane_o) && $stable(dim_o)));

endmodule

// File: rtl/tw_disp_loader.sv
// Top of the three-wire addressed display loader: synchronises the host
// pins, receives and checks frames, and holds the display registers.
// Assumes the host keeps each line level for a few system clocks.
module tw_disp_loader
    import tw_loader_pkg::*;
#(
    parameter int unsigned SEG_W       = 56,
    parameter int unsigned DIM_W       = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_cs,
    input  logic             ser_clk,
    input  logic             ser_dat,
    output logic [SEG_W-1:0] seg_plane1,
    output logic [SEG_W-1:0] seg_plane2,
    output logic [SEG_W-1:0] seg_plane3,
    output logic [DIM_W-1:0] dim_level
);

    logic [2:0]                   pins_s;
    logic                         wr_en;
    logic [ADDR_W-1:0]            wr_addr;
    logic [SEG_W-1:0]             wr_data;
    logic [PLANES-1:0][SEG_W-1:0] planes;

    tw_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_dat, ser_clk, ser_cs}),
        .sync_o  (pins_s)
    );

    tw_frame_shifter #(
        .SEG_W (SEG_W),
        .DIM_W (DIM_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (pins_s[0]),
        .sclk_s  (pins_s[1]),
        .dat_s   (pins_s[2]),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    tw_latch_bank #(
        .SEG_W (SEG_W),
        .DIM_W (DIM_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .plane_o (planes),
        .dim_o   (dim_level)
    );

    assign seg_plane1 = planes[0];
    assign seg_plane2 = planes[1];
    assign seg_plane3 = planes[2];

endmodule

// File: tb/tw_disp_loader_tb.sv
module tw_disp_loader_tb;

    localparam int SEG_W = 56;
    localparam int DIM_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_cs = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic [SEG_W-1:0] seg_plane1, seg_plane2, seg_plane3;
    logic [DIM_W-1:0] dim_level;

    int checks = 0;
    int fails = 0;
    logic [SEG_W-1:0] exp_pl [3];
    logic [DIM_W-1:0] exp_dim;

    tw_disp_loader u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_cs     (ser_cs),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .seg_plane1 (seg_plane1),
        .seg_plane2 (seg_plane2),
        .seg_plane3 (seg_plane3),
        .dim_level  (dim_level)
    );

    always #10 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare every output; the addressed one gets tag_hit, others tag_rest.
    task automatic check_all(input int hit, input string tag_hit, input string tag_rest);
        chk(hit == 1 ? tag_hit : tag_rest, "plane1", 64'(seg_plane1), 64'(exp_pl[0]));
        chk(hit == 2 ? tag_hit : tag_rest, "plane2", 64'(seg_plane2), 64'(exp_pl[1]));
        chk(hit == 3 ? tag_hit : tag_rest, "plane3", 64'(seg_plane3), 64'(exp_pl[2]));
        chk(hit == 4 ? tag_hit : tag_rest, "dim",    64'(dim_level),  64'(exp_dim));
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        step(3);
        ser_clk = 1'b1;
        step(3);
        ser_clk = 1'b0;
    endtask

    // Send one frame: 3 address bits MSB first, then n payload bits MSB first.
    task automatic send_frame(input logic [2:0] a, input int n, input logic [63:0] d);
        ser_cs = 1'b1;
        step(4);
        for (int i = 0; i < 3; i++) shift_bit(a[2-i]);
        for (int i = 0; i < n; i++) shift_bit(d[n-1-i]);
        step(4);
        check_all(0, "R5", "R5");   // nothing committed while select high
        ser_cs = 1'b0;
        step(8);
    endtask

    // Send a frame, update the model from the requirements, check outputs.
    task automatic run_frame(input logic [2:0] a, input int n, input logic [63:0] d,
                             input string extra);
        int hit;
        string tag;
        hit = 0;
        send_frame(a, n, d);
        if (a >= 3'd1 && a <= 3'd3 && n == SEG_W) begin
            exp_pl[a-1] = d[SEG_W-1:0];
            hit = int'(a);
            tag = {"R2 R3 ", extra};
        end else if (a == 3'd4 && n == DIM_W) begin
            exp_dim = d[DIM_W-1:0];
            hit = 4;
            tag = {"R4 ", extra};
        end else if (a == 3'd0 || a > 3'd4) begin
            tag = {"R7 ", extra};
        end else begin
            tag = {"R6 ", extra};
        end
        check_all(hit, tag, hit != 0 ? {"R9 ", extra} : tag);
    endtask

    function automatic logic [63:0] pat(input int k);
        logic [31:0] hi, lo;
        hi = 32'(k) * 32'h9E3779B1 + 32'h1234567;
        lo = (32'(k) + 32'd7) * 32'h85EBCA77;
        return {hi, lo};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lens [7];
        lens = '{0, 9, 10, 11, 55, 56, 57};
        for (int i = 0; i < 3; i++) exp_pl[i] = '0;
        exp_dim = '0;
        step(5);
        check_all(0, "R1", "R1");
        rst_n = 1'b1;
        step(1);
        check_all(0, "R1", "R1");

        // R3 bit placement at both ends of the field, and all ones
        run_frame(3'd1, SEG_W, 64'h1, "lsb");
        run_frame(3'd1, SEG_W, 64'(1) << (SEG_W - 1), "msb");
        run_frame(3'd2, SEG_W, {64{1'b1}}, "ones");
        run_frame(3'd4, DIM_W, 64'h200, "dim_msb");

        // Sweep every code against lengths around the valid counts (R6, R7)
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 8; a++) begin
                for (int li = 0; li < 7; li++) begin
                    run_frame(3'(a), lens[li], pat(pass * 100 + a * 10 + li), "sweep");
                end
            end
        end

        // R8: clock edges with select low are ignored
        for (int i = 0; i < 20; i++) begin
            ser_dat = pat(i)[5];
            step(2);
            ser_clk = 1'b1;
            step(2);
            ser_clk = 1'b0;
        end
        step(6);
        check_all(0, "R8", "R8");
        run_frame(3'd3, SEG_W, pat(777), "R8_after_idle");
        run_frame(3'd4, DIM_W, pat(778), "R8_after_idle");

        // R1: reset again clears everything
        rst_n = 1'b0;
        step(3);
        for (int i = 0; i < 3; i++) exp_pl[i] = '0;
        exp_dim = '0;
        check_all(0, "R1", "R1");
        rst_n = 1'b1;
        step(2);
        check_all(0, "R1", "R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule